// File: doc/BRIEF.md
# Serial-Presence-Detect Write-Protection Controller

This block is the memory-side decision logic of a 256 x 8 serial-presence-detect store on a two-wire bus. A byte-level bus front end gives it the address byte, the word-pointer byte and the data bytes, each as a one-cycle strobe, plus a stop strobe. For every byte the block returns a registered acknowledge decision. For accepted data bytes it drives a write enable, address and data into a register-array model.

The block recognises two device-type codes. Code `1010` reaches the array and code `0110` reaches the protection settings. In both cases the three pin bits of the address byte must equal `dev_sel`. A lock flag guards the lower half of the array (00h-7Fh). The lock can be set in a resettable form, which a later clear command can remove, or in a permanent form, which nothing short of reset removes. There is no hardware write-control input, so only the lock decides whether a write is allowed. A stop that ends a transaction with at least one applied write or command starts a fixed busy period. During that period every byte is refused.

The state machine has these states:
- `ST_IDLE`: waiting for an address.
- `ST_ARR_PTR`: waiting for the word pointer.
- `ST_ARR_DATA`: accepting data bytes.
- `ST_PROT_CMD`: waiting for the protection command byte.
- `ST_SINK`: reads, ignored transactions and bytes after a command.
- `ST_BUSY`: the write cycle in progress.

Transitions:
- From any state except `ST_BUSY`, an address strobe redirects to `ST_ARR_PTR`, `ST_PROT_CMD` or `ST_SINK`.
- A pointer strobe moves `ST_ARR_PTR` to `ST_ARR_DATA`.
- A command strobe moves `ST_PROT_CMD` to `ST_SINK`.
- A stop moves to `ST_BUSY` if work was applied, otherwise to `ST_IDLE`.
- `ST_BUSY` returns to `ST_IDLE` when the timer expires.

Top module: `spd_wp_ctrl`

## Requirements
- R1: An address byte with bits [7:4]=1010, bits [3:1]=`dev_sel` and bit 0=0 is acknowledged. The next pointer byte is acknowledged and loads the word pointer. Each following data byte that is accepted raises `mem_we` for one cycle with `mem_addr`=pointer and `mem_wdata`=byte. After every data byte the pointer advances by one and wraps from FFh to 00h.
- R2: An address byte with bits [7:4]=0110 and matching pin bits is acknowledged while the lock is not permanent.
- R3: An address byte whose pin bits differ from `dev_sel`, or whose type code is neither 1010 nor 0110, is not acknowledged. Later bytes in that transaction are not acknowledged, nothing is written and the lock is unchanged.
- R4: While `wp_locked`=1, a data byte aimed at 00h-7Fh is not acknowledged and causes no write, though the pointer still advances. Data aimed at 80h-FFh is always written.
- R5: The protection command byte (sent in pointer position) takes these values: 01h sets a resettable lock, 02h sets a permanent lock, 03h clears a resettable lock. These are acknowledged; any other value is not. `wp_locked` and `wp_permanent` report the result.
- R6: Once `wp_permanent`=1, addresses of type 0110 are not acknowledged and the lock stays set until reset.
- R7: A stop after at least one applied write or command sets `busy` for BUSY_CYC cycles. Every byte strobed during that time gets a negative acknowledge.
- R8: After reset the lock is clear, `busy`=0 and no acknowledge or write strobe is raised.
- R9: A read address (bit 0=1) of either type that passes the match is acknowledged without changing state. A stop after only reads or ignored bytes returns to idle with no busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_sel | input | 3 | Configured address-pin bits |
| addr_valid | input | 1 | Address byte strobe |
| addr_byte | input | 8 | Address byte (type, pins, R/W) |
| ptr_valid | input | 1 | Pointer/command byte strobe |
| ptr_byte | input | ADDR_W | Pointer or command byte |
| data_valid | input | 1 | Data byte strobe |
| data_byte | input | DATA_W | Data byte |
| stop | input | 1 | End-of-transaction strobe |
| ack_strobe | output | 1 | Acknowledge decision valid |
| ack | output | 1 | 1 = acknowledge, 0 = refuse |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| wp_locked | output | 1 | Lower half locked |
| wp_permanent | output | 1 | Lock is permanent |
| busy | output | 1 | Write cycle in progress |

## Verification
Every acknowledge decision and every `mem_we` pulse comes one clock after the strobe that caused it. The driver task pushes the expected decision into a queue in the cycle it drives the strobe. The monitor pops from that queue on the next falling edge on which `ack_strobe` is high, and a separate queue holds the expected array writes. `busy` is high from the clock after the stop for BUSY_CYC cycles. The bench probes it with a strobe on the very next cycle and waits BUSY_CYC+2 cycles before the next transaction. The lock status outputs change on the edge that samples the command byte and are read only after the following stop.

// File: rtl/spd_wp_pkg.sv
package spd_wp_pkg;
    localparam logic [3:0] DT_ARRAY = 4'b1010;
    localparam logic [3:0] DT_PROT  = 4'b0110;

    localparam logic [7:0] CMD_LOCK_SOFT = 8'h01;
    localparam logic [7:0] CMD_LOCK_HARD = 8'h02;
    localparam logic [7:0] CMD_UNLOCK    = 8'h03;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARR_PTR,
        ST_ARR_DATA,
        ST_PROT_CMD,
        ST_SINK,
        ST_BUSY
    } wp_state_e;
endpackage

// File: rtl/spd_addr_dec.sv
module spd_addr_dec
    import spd_wp_pkg::*;
(
    input  logic [7:0] addr_byte,
    input  logic [2:0] dev_sel,
    output logic       hit_arr,
    output logic       hit_prot,
    output logic       rd
);
    logic pins_ok;

    always_comb begin
        pins_ok  = (addr_byte[3:1] == dev_sel);
        hit_arr  = pins_ok && (addr_byte[7:4] == DT_ARRAY);
        hit_prot = pins_ok && (addr_byte[7:4] == DT_PROT);
        rd       = addr_byte[0];
    end
endmodule

// File: rtl/spd_wp_lock.sv
module spd_wp_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic set_soft,
    input  logic set_hard,
    input  logic clr,
    output logic locked,
    output logic permanent
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked    <= 1'b0;
            permanent <= 1'b0;
        end else if (!permanent) begin
            if (set_hard) begin
                locked    <= 1'b1;
                permanent <= 1'b1;
            end else if (set_soft) begin
                locked <= 1'b1;
            end else if (clr) begin
                locked <= 1'b0;
            end
        end
    end

    AST_PERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        permanent |=> (permanent && locked)); // R6
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_soft && !set_hard && !permanent) |=> !locked); // R5
endmodule

// File: rtl/spd_busy_timer.sv
module spd_busy_timer #(
    parameter int BUSY_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CNT_W'(BUSY_CYC);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    always_comb done = (cnt_q == CNT_W'(1));

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(BUSY_CYC)); // R7
    AST_START_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (cnt_q == '0)); // R7
endmodule

// File: rtl/spd_wp_ctrl.sv
module spd_wp_ctrl
    import spd_wp_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int BUSY_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        dev_sel,
    input  logic              addr_valid,
    input  logic [7:0]        addr_byte,
    input  logic              ptr_valid,
    input  logic [ADDR_W-1:0] ptr_byte,
    input  logic              data_valid,
    input  logic [DATA_W-1:0] data_byte,
    input  logic              stop,
    output logic              ack_strobe,
    output logic              ack,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              wp_locked,
    output logic              wp_permanent,
    output logic              busy
);
    localparam int PROT_BIT = ADDR_W - 1;

    wp_state_e         st_q, st_n;
    logic [ADDR_W-1:0] ptr_q, ptr_n;
    logic              wrote_q, wrote_n;
    logic              hit_arr, hit_prot, rd;
    logic              t_start, t_done;
    logic              c_soft, c_hard, c_clr;
    logic              a_v, a_k, we_n;
    logic              any_byte;

    spd_addr_dec u_dec (
        .addr_byte (addr_byte),
        .dev_sel   (dev_sel),
        .hit_arr   (hit_arr),
        .hit_prot  (hit_prot),
        .rd        (rd)
    );

    spd_wp_lock u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_soft  (c_soft),
        .set_hard  (c_hard),
        .clr       (c_clr),
        .locked    (wp_locked),
        .permanent (wp_permanent)
    );

    spd_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (t_start),
        .done  (t_done)
    );

    always_comb any_byte = addr_valid || ptr_valid || data_valid;

    always_comb begin
        st_n    = st_q;
        ptr_n   = ptr_q;
        wrote_n = wrote_q;
        a_v     = 1'b0;
        a_k     = 1'b0;
        we_n    = 1'b0;
        c_soft  = 1'b0;
        c_hard  = 1'b0;
        c_clr   = 1'b0;
        t_start = 1'b0;
        if (st_q == ST_BUSY) begin
            a_v = any_byte;
            if (t_done)
                st_n = ST_IDLE;
        end else if (stop) begin
            wrote_n = 1'b0;
            if (wrote_q) begin
                st_n    = ST_BUSY;
                t_start = 1'b1;
            end else begin
                st_n = ST_IDLE;
            end
        end else if (addr_valid) begin
            a_v = 1'b1;
            if (hit_arr) begin
                a_k  = 1'b1;
                st_n = rd ? ST_SINK : ST_ARR_PTR;
            end else if (hit_prot && !wp_permanent) begin
                a_k  = 1'b1;
                st_n = rd ? ST_SINK : ST_PROT_CMD;
            end else begin
                st_n = ST_SINK;
            end
        end else if (ptr_valid || data_valid) begin
            a_v = 1'b1;
            unique case (st_q)
                ST_ARR_PTR: begin
                    if (ptr_valid) begin
                        a_k   = 1'b1;
                        ptr_n = ptr_byte;
                        st_n  = ST_ARR_DATA;
                    end
                end
                ST_ARR_DATA: begin
                    if (data_valid) begin
                        a_k   = !(wp_locked && !ptr_q[PROT_BIT]);
                        we_n  = a_k;
                        ptr_n = ptr_q + 1'b1;
                        if (a_k)
                            wrote_n = 1'b1;
                    end
                end
                ST_PROT_CMD: begin
                    if (ptr_valid) begin
                        st_n = ST_SINK;
                        unique case (8'(ptr_byte))
                            CMD_LOCK_SOFT: c_soft = 1'b1;
                            CMD_LOCK_HARD: c_hard = 1'b1;
                            CMD_UNLOCK:    c_clr  = 1'b1;
                            default:       ;
                        endcase
                        a_k = c_soft || c_hard || c_clr;
                        if (a_k)
                            wrote_n = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            ptr_q   <= '0;
            wrote_q <= 1'b0;
        end else begin
            st_q    <= st_n;
            ptr_q   <= ptr_n;
            wrote_q <= wrote_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_strobe <= 1'b0;
            ack        <= 1'b0;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
        end else begin
            ack_strobe <= a_v;
            ack        <= a_k;
            mem_we     <= we_n;
            mem_addr   <= ptr_q;
            mem_wdata  <= data_byte;
        end
    end

    always_comb busy = (st_q == ST_BUSY);

    AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && any_byte) |=> (ack_strobe && !ack)); // R7
    AST_LOW_HALF_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_addr[PROT_BIT]) |-> !wp_locked); // R4
    AST_WE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (ack_strobe && ack)); // R1
    AST_PIN_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_byte[3:1] != dev_sel) |=> !ack); // R3
    AST_PERM_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_byte[7:4] == DT_PROT && wp_permanent) |=> !ack); // R6
endmodule

// File: tb/spd_wp_ctrl_tb.sv
module spd_wp_ctrl_tb;
    localparam int BUSY_CYC = 20;
    localparam logic [2:0] SEL = 3'b101;
    localparam logic [7:0] A_ARR_W = {4'b1010, SEL, 1'b0};
    localparam logic [7:0] A_ARR_R = {4'b1010, SEL, 1'b1};
    localparam logic [7:0] A_PRT_W = {4'b0110, SEL, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_valid = 1'b0, ptr_valid = 1'b0, data_valid = 1'b0, stop = 1'b0;
    logic [7:0] addr_byte = '0, ptr_byte = '0, data_byte = '0;
    logic ack_strobe, ack, mem_we, wp_locked, wp_permanent, busy;
    logic [7:0] mem_addr, mem_wdata;

    int checks = 0;
    int errors = 0;

    logic  exp_ack_q[$];
    string exp_tag_q[$];
    logic [15:0] exp_wr_q[$];

    always #2.5 clk = ~clk;

    spd_wp_ctrl #(.ADDR_W(8), .DATA_W(8), .BUSY_CYC(BUSY_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .dev_sel(SEL),
        .addr_valid(addr_valid), .addr_byte(addr_byte),
        .ptr_valid(ptr_valid), .ptr_byte(ptr_byte),
        .data_valid(data_valid), .data_byte(data_byte), .stop(stop),
        .ack_strobe(ack_strobe), .ack(ack), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .wp_locked(wp_locked), .wp_permanent(wp_permanent), .busy(busy)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected decisions and writes as the design produces them
    always @(negedge clk) begin
        if (rst_n && ack_strobe) begin
            if (exp_ack_q.size() == 0) check("R3 unexpected ack strobe", 16'd1, 16'd0);
            else check(exp_tag_q.pop_front(), 16'(ack), 16'(exp_ack_q.pop_front()));
        end
        if (rst_n && mem_we) begin
            if (exp_wr_q.size() == 0) check("R4 unexpected write", {mem_addr, mem_wdata}, 16'hxxxx);
            else check("R1 write addr/data", {mem_addr, mem_wdata}, exp_wr_q.pop_front());
        end
    end

    task automatic put(input int kind, input logic [7:0] b, input logic e, input string tag);
        @(negedge clk);
        case (kind)
            0: begin addr_byte = b; addr_valid = 1'b1; end
            1: begin ptr_byte = b;  ptr_valid  = 1'b1; end
            default: begin data_byte = b; data_valid = 1'b1; end
        endcase
        exp_ack_q.push_back(e);
        exp_tag_q.push_back(tag);
        @(negedge clk);
        addr_valid = 1'b0; ptr_valid = 1'b0; data_valid = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] a, input logic [7:0] d, input logic e, input string tag);
        if (e) exp_wr_q.push_back({a, d});
        put(2, d, e, tag);
    endtask

    task automatic end_txn(input logic expect_busy, input string tag);
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check(tag, 16'(busy), 16'(expect_busy));
        if (expect_busy) begin
            repeat (BUSY_CYC + 2) @(negedge clk);
            check("R7 busy ends", 16'(busy), 16'd0);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        check("watchdog expired", 16'd1, 16'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 locked", 16'(wp_locked), 16'd0);
        check("R8 permanent", 16'(wp_permanent), 16'd0);
        check("R8 busy", 16'(busy), 16'd0);
        check("R8 ack strobe", 16'(ack_strobe), 16'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 plain write of two bytes with auto-increment
        put(0, A_ARR_W, 1'b1, "R1 addr");
        put(1, 8'h10, 1'b1, "R1 ptr");
        wr_data(8'h10, 8'h55, 1'b1, "R1 data0");
        wr_data(8'h11, 8'h66, 1'b1, "R1 data1");
        @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0;
        check("R7 busy after stop", 16'(busy), 16'd1);
        put(0, A_ARR_W, 1'b0, "R7 nack while busy");
        repeat (BUSY_CYC + 2) @(negedge clk);
        check("R7 busy ends", 16'(busy), 16'd0);

        // R1 pointer wrap at FFh
        put(0, A_ARR_W, 1'b1, "R1 addr");
        put(1, 8'hFF, 1'b1, "R1 ptr");
        wr_data(8'hFF, 8'hA1, 1'b1, "R1 data ff");
        wr_data(8'h00, 8'hA2, 1'b1, "R1 wrap data");
        end_txn(1'b1, "R7 busy");

        // R3 pin mismatch and foreign type code
        put(0, {4'b1010, 3'b001, 1'b0}, 1'b0, "R3 pin mismatch");
        put(1, 8'h20, 1'b0, "R3 ptr ignored");
        put(2, 8'h77, 1'b0, "R3 data ignored");
        end_txn(1'b0, "R3 no busy");
        put(0, {4'b0101, SEL, 1'b0}, 1'b0, "R3 foreign code");
        put(0, {4'b0110, 3'b000, 1'b0}, 1'b0, "R3 prot pin mismatch");
        end_txn(1'b0, "R3 no busy");
        check("R3 lock unchanged", 16'(wp_locked), 16'd0);

        // R9 read address acked, no busy
        put(0, A_ARR_R, 1'b1, "R9 read addr");
        end_txn(1'b0, "R9 no busy");

        // R2 R5 resettable lock
        put(0, A_PRT_W, 1'b1, "R2 prot addr");
        put(1, 8'h01, 1'b1, "R5 set resettable");
        end_txn(1'b1, "R7 busy after cmd");
        check("R5 locked", 16'(wp_locked), 16'd1);
        check("R5 not permanent", 16'(wp_permanent), 16'd0);

        // R4 low half refused, pointer advances across 7Fh->80h
        put(0, A_ARR_W, 1'b1, "R4 addr");
        put(1, 8'h7F, 1'b1, "R4 ptr");
        wr_data(8'h7F, 8'h11, 1'b0, "R4 data 7F refused");
        wr_data(8'h80, 8'h22, 1'b1, "R4 data 80 written");
        end_txn(1'b1, "R7 busy");
        put(0, A_ARR_W, 1'b1, "R4 addr");
        put(1, 8'h20, 1'b1, "R4 ptr");
        wr_data(8'h20, 8'h33, 1'b0, "R4 data 20 refused");
        end_txn(1'b0, "R4 no busy after refused");

        // R5 unknown command
        put(0, A_PRT_W, 1'b1, "R2 prot addr");
        put(1, 8'h07, 1'b0, "R5 unknown cmd");
        end_txn(1'b0, "R5 no busy");
        check("R5 still locked", 16'(wp_locked), 16'd1);

        // R5 clear
        put(0, A_PRT_W, 1'b1, "R2 prot addr");
        put(1, 8'h03, 1'b1, "R5 clear");
        end_txn(1'b1, "R7 busy");
        check("R5 cleared", 16'(wp_locked), 16'd0);
        put(0, A_ARR_W, 1'b1, "R4 addr");
        put(1, 8'h20, 1'b1, "R4 ptr");
        wr_data(8'h20, 8'h44, 1'b1, "R4 low write when unlocked");
        end_txn(1'b1, "R7 busy");

        // R6 permanent lock
        put(0, A_PRT_W, 1'b1, "R2 prot addr");
        put(1, 8'h02, 1'b1, "R5 set permanent");
        end_txn(1'b1, "R7 busy");
        check("R6 permanent", 16'(wp_permanent), 16'd1);
        check("R6 locked", 16'(wp_locked), 16'd1);
        put(0, A_PRT_W, 1'b0, "R6 prot addr refused");
        put(1, 8'h03, 1'b0, "R6 clear ignored");
        end_txn(1'b0, "R6 no busy");
        check("R6 still locked", 16'(wp_locked), 16'd1);
        put(0, A_ARR_W, 1'b1, "R6 addr");
        put(1, 8'h00, 1'b1, "R6 ptr");
        wr_data(8'h00, 8'h99, 1'b0, "R6 low refused");
        end_txn(1'b0, "R6 no busy");
        put(0, A_ARR_W, 1'b1, "R6 addr");
        put(1, 8'hC0, 1'b1, "R6 ptr");
        wr_data(8'hC0, 8'h5A, 1'b1, "R6 high written");
        end_txn(1'b1, "R7 busy");

        repeat (3) @(negedge clk);
        check("R1 ack queue drained", 16'(exp_ack_q.size()), 16'd0);
        check("R1 write queue drained", 16'(exp_wr_q.size()), 16'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule